// File: doc/BRIEF.md
# Branch Resolution and Flush Unit

This block owns the fetch program counter of a five-stage in-order pipeline and settles control transfers once they reach the execute stage. After reset the counter starts at the base of the code space. It then steps one instruction (four bytes) per cycle unless the interlock asks it to hold.

When execute holds a valid conditional or jump operation, the block works out the destination. A zero-test or nonzero-test branch goes to its own address plus a literal. A jump goes to a register value plus a literal. The block also decides whether the transfer is taken. A taken transfer to a legal address does three things in the same cycle:

- it raises the kill strobes for the fetch and decode pipeline registers, so those stages drop their valid bits;
- it loads the new address into the counter on the next clock edge;
- it overrides any stall raised in that cycle.

A taken transfer to an address that is not word aligned, or that lies below the code base, does not redirect. It raises an error strobe instead.

Top module: `br_flush_unit`

## Requirements
- R1: After reset is released, `fetch_pc` equals the code base address, 4000 by default.
- R2: With no redirect and `stall` low, `fetch_pc` advances by 4 at each rising clock edge.
- R3: With no redirect and `stall` high, `fetch_pc` keeps its value across the edge.
- R4: The zero-test branch (`ex_op` = 2'b01) is taken only when `zero_flag` is 1. Its target is `ex_pc + ex_lit`, using two's-complement wrap at 32 bits.
- R5: The nonzero-test branch (`ex_op` = 2'b10) is taken only when `zero_flag` is 0. Its target is `ex_pc + ex_lit`.
- R6: The jump (`ex_op` = 2'b11) is taken whenever `ex_valid` is 1, whatever `zero_flag` is. Its target is `ex_reg + ex_lit`.
- R7: A taken transfer with a legal target raises `flush_fetch` and `flush_decode` in the same cycle, and `fetch_pc` equals the target after the next rising edge.
- R8: If `ex_valid` is 0, or `ex_op` = 2'b00, or a conditional branch is not taken, then no flush strobe and no error is raised and the counter follows R2/R3.
- R9: A taken transfer whose target has bits [1:0] not equal to 0, or whose target is below the code base, raises `target_err` in that cycle. It raises no flush strobe, and the counter follows R2/R3.
- R10: A legal taken transfer redirects and flushes even when `stall` is high in the same cycle.
- R11: `fetch_pc` is at all times word aligned and not below the code base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Interlock request to hold fetch |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_op | input | 2 | 00 other, 01 zero-test branch, 10 nonzero-test branch, 11 jump |
| zero_flag | input | 1 | Architectural zero flag |
| ex_pc | input | 32 | Address of the instruction in execute |
| ex_reg | input | 32 | Register operand for the jump |
| ex_lit | input | 32 | Signed literal offset |
| fetch_pc | output | 32 | Address to fetch in this cycle |
| flush_fetch | output | 1 | Kill the fetch-stage pipeline register |
| flush_decode | output | 1 | Kill the decode-stage pipeline register |
| target_err | output | 1 | Taken transfer with an illegal target |

## Verification
Two functions can fall in the same cycle: a taken redirect and an interlock stall. They pull the counter in opposite directions. The bench sweeps every combination of `ex_valid`, `ex_op`, `zero_flag` and `stall` against a set of literals and register values. That set includes misaligned targets, targets below the base, and backward targets. For each case the bench predicts the strobes arithmetically, and it predicts the counter after the edge with the redirect taking priority over the stall. It then checks both at the ports.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int PC_W = 32;

  typedef enum logic [1:0] {
    OP_OTHER = 2'b00,
    OP_BRZ   = 2'b01,
    OP_BRNZ  = 2'b10,
    OP_JMP   = 2'b11
  } br_op_e;

  // Sequential step of the fetch address.
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc,
                                               input int unsigned step);
    return pc + PC_W'(step);
  endfunction

  // Destination of a transfer: PC-relative for branches, register-based for jumps.
  function automatic logic [PC_W-1:0] xfer_target(input br_op_e op,
                                                  input logic [PC_W-1:0] pc,
                                                  input logic [PC_W-1:0] rv,
                                                  input logic [PC_W-1:0] lit);
    return ((op == OP_JMP) ? rv : pc) + lit;
  endfunction

  // Whether a transfer is taken.
  function automatic logic xfer_taken(input br_op_e op, input logic zf);
    case (op)
      OP_BRZ:  return zf;
      OP_BRNZ: return !zf;
      OP_JMP:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Legal target: aligned to the instruction size and inside the code space.
  function automatic logic target_legal(input logic [PC_W-1:0] t,
                                        input logic [PC_W-1:0] base,
                                        input logic [PC_W-1:0] mask);
    return ((t & mask) == '0) && (t >= base);
  endfunction
endpackage

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int unsigned BASE_ADDR  = 4000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            ex_valid,
  input  logic [1:0]      ex_op,
  input  logic            zero_flag,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [PC_W-1:0] ex_reg,
  input  logic [PC_W-1:0] ex_lit,
  output logic            taken,
  output logic            legal,
  output logic [PC_W-1:0] target
);
  localparam logic [PC_W-1:0] BASE_V = PC_W'(BASE_ADDR);
  localparam logic [PC_W-1:0] MASK_V = PC_W'(INSN_BYTES - 1);

  br_op_e op;

  always_comb begin
    op     = br_op_e'(ex_op);
    target = xfer_target(op, ex_pc, ex_reg, ex_lit);
    taken  = ex_valid && xfer_taken(op, zero_flag);
    legal  = target_legal(target, BASE_V, MASK_V);
  end
endmodule

// File: rtl/br_pc_reg.sv
module br_pc_reg
  import br_pkg::*;
#(
  parameter int unsigned BASE_ADDR  = 4000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  // A redirect is checked first, so it wins over a stall in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= PC_W'(BASE_ADDR);
    else if (redirect) pc <= target;
    else if (!stall)   pc <= seq_next(pc, INSN_BYTES);
  end
endmodule

// File: rtl/br_flush_unit.sv
module br_flush_unit
  import br_pkg::*;
#(
  parameter int unsigned BASE_ADDR  = 4000,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        ex_valid,
  input  logic [1:0]  ex_op,
  input  logic        zero_flag,
  input  logic [31:0] ex_pc,
  input  logic [31:0] ex_reg,
  input  logic [31:0] ex_lit,
  output logic [31:0] fetch_pc,
  output logic        flush_fetch,
  output logic        flush_decode,
  output logic        target_err
);
  // Internal events, brought out by name for the checker.
  logic            xfer_taken_w;
  logic            xfer_legal_w;
  logic [PC_W-1:0] xfer_target_w;
  logic            redirect_w;

  br_resolve #(.BASE_ADDR(BASE_ADDR), .INSN_BYTES(INSN_BYTES)) u_resolve (
    .ex_valid (ex_valid),
    .ex_op    (ex_op),
    .zero_flag(zero_flag),
    .ex_pc    (ex_pc),
    .ex_reg   (ex_reg),
    .ex_lit   (ex_lit),
    .taken    (xfer_taken_w),
    .legal    (xfer_legal_w),
    .target   (xfer_target_w)
  );

  assign redirect_w   = xfer_taken_w && xfer_legal_w;
  assign flush_fetch  = redirect_w;
  assign flush_decode = redirect_w;
  assign target_err   = xfer_taken_w && !xfer_legal_w;

  br_pc_reg #(.BASE_ADDR(BASE_ADDR), .INSN_BYTES(INSN_BYTES)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall   (stall),
    .redirect(redirect_w),
    .target  (xfer_target_w),
    .pc      (fetch_pc)
  );
endmodule

// File: rtl/br_flush_unit_chk.sv
module br_flush_unit_chk #(
  parameter int unsigned BASE_ADDR  = 4000,
  parameter int unsigned INSN_BYTES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        ex_valid,
  input logic [1:0]  ex_op,
  input logic        zero_flag,
  input logic [31:0] fetch_pc,
  input logic        flush_fetch,
  input logic        flush_decode,
  input logic        target_err,
  input logic [31:0] xfer_target_w
);
  // R2: sequential step
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_fetch && !target_err && !stall) |=> fetch_pc == $past(fetch_pc) + 32'(INSN_BYTES));

  // R3: hold while stalled
  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_fetch && stall) |=> $stable(fetch_pc));

  // R7: the counter loads the target after a flush
  a_r7_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch |=> fetch_pc == $past(xfer_target_w));

  // R7: both kill strobes together
  a_r7_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch == flush_decode);

  // R8: an untaken zero-test branch never flushes
  a_r8_brz_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b01 && !zero_flag) |-> !flush_fetch && !target_err);

  // R8: an untaken nonzero-test branch never flushes
  a_r8_brnz_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b10 && zero_flag) |-> !flush_fetch && !target_err);

  // R9: an error excludes a flush
  a_r9_err_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    target_err |-> !flush_fetch && !flush_decode);

  // R10: a flush wins over a stall
  a_r10_flush_over_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_fetch && stall) |=> fetch_pc == $past(xfer_target_w));

  // R11: the counter stays aligned and inside the code space
  a_r11_pc_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pc[1:0] == 2'b00) && (fetch_pc >= 32'(BASE_ADDR)));
endmodule

bind br_flush_unit br_flush_unit_chk #(.BASE_ADDR(BASE_ADDR), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .ex_valid     (ex_valid),
  .ex_op        (ex_op),
  .zero_flag    (zero_flag),
  .fetch_pc     (fetch_pc),
  .flush_fetch  (flush_fetch),
  .flush_decode (flush_decode),
  .target_err   (target_err),
  .xfer_target_w(xfer_target_w)
);

// File: tb/br_flush_unit_test.sv
`timescale 1ns/1ps
module br_flush_unit_test;
  localparam int unsigned BASE = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        ex_valid = 1'b0;
  logic [1:0]  ex_op = 2'b00;
  logic        zero_flag = 1'b0;
  logic [31:0] ex_pc = 32'd4000;
  logic [31:0] ex_reg = 32'd0;
  logic [31:0] ex_lit = 32'd0;
  logic [31:0] fetch_pc;
  logic        flush_fetch, flush_decode, target_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  br_flush_unit uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .ex_valid(ex_valid),
    .ex_op(ex_op), .zero_flag(zero_flag), .ex_pc(ex_pc), .ex_reg(ex_reg),
    .ex_lit(ex_lit), .fetch_pc(fetch_pc), .flush_fetch(flush_fetch),
    .flush_decode(flush_decode), .target_err(target_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic string tag_for(input logic [1:0] op, input logic v,
                                    input logic tk, input logic ok, input logic st);
    if (!v || !tk)     return "R8";
    if (!ok)           return "R9";
    if (st)            return "R10";
    if (op == 2'b01)   return "R4";
    if (op == 2'b10)   return "R5";
    return "R6";
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lits [7];
    logic [31:0] regs [4];
    lits = '{32'd8, -32'sd8, 32'd12, 32'd2, -32'sd4000, 32'd0, 32'd400};
    regs = '{32'd4000, 32'd4100, 32'd3, 32'd0};

    stall = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "fetch_pc after reset", fetch_pc, 32'd4000);
    exp_pc = 32'd4000;

    // Plain sequential fetch.
    stall = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      exp_pc = exp_pc + 4;
      check("R2", "sequential step", fetch_pc, exp_pc);
    end

    // Sweep.
    for (int op = 0; op < 4; op++)
      for (int z = 0; z < 2; z++)
        for (int v = 0; v < 2; v++)
          for (int st = 0; st < 2; st++)
            for (int li = 0; li < 7; li++)
              for (int ri = 0; ri < 4; ri++) begin
                logic [31:0] tgt;
                logic tk, ok, rd;
                string tg;
                ex_op = op[1:0]; zero_flag = z[0]; ex_valid = v[0]; stall = st[0];
                ex_lit = lits[li]; ex_reg = regs[ri];
                ex_pc = 32'd4000 + 32'(8 * (li + ri));
                #1;
                tgt = ((op == 3) ? ex_reg : ex_pc) + ex_lit;
                tk = v[0] && ((op == 1 && z == 1) || (op == 2 && z == 0) || op == 3);
                ok = (tgt[1:0] == 2'b00) && (tgt >= 32'(BASE));
                rd = tk && ok;
                tg = tag_for(op[1:0], v[0], tk, ok, st[0]);
                check(rd ? "R7" : tg, "flush_fetch", {31'd0, flush_fetch}, {31'd0, rd});
                check(rd ? "R7" : tg, "flush_decode", {31'd0, flush_decode}, {31'd0, rd});
                check(tg, "target_err", {31'd0, target_err}, {31'd0, tk && !ok});
                if (rd) exp_pc = tgt;
                else if (!st[0]) exp_pc = exp_pc + 4;
                @(negedge clk);
                check(rd ? tg : (st[0] ? "R3" : "R2"), "fetch_pc next", fetch_pc, exp_pc);
                check("R11", "fetch_pc legal",
                      {31'd0, (fetch_pc[1:0] == 2'b00) && (fetch_pc >= 32'(BASE))}, 32'd1);
              end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule